// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block is a register-mapped front end that launches one NAND flash operation at a time. Software loads a command byte and an address byte into their own registers, then writes a one-hot trigger word. The sequencer drives the command-latch, address-latch, write-strobe and read-strobe pins for that operation and raises a sticky completion flag that software polls. The block supports six operations: a command cycle, an address cycle, a page program from the buffer, a page read into the buffer, an ID read and a status read.

Page transfers hand bytes to and from an external page buffer through a small port. The port carries a 3-bit area pointer and a byte index. The block also holds the chip-select number and the chip-enable bit that drive one of four active-low chip enables, a pages-per-block code, and a soft reset that clears itself. Program and page-read operations respect the device's ready/busy line. Multi-step sequences, such as a large-page read with two column cycles followed by a read-start command, are built by software as a series of single triggers.

Top module: `nand_op_seq`

## Requirements
- R1: A trigger value of 0x0001 (command) makes one write strobe while CLE is high, with the command register byte (register 0, bits 7:0) on `nand_dout`.
- R2: A trigger value of 0x0002 (address) makes one write strobe while ALE is high, with the address register byte (register 1, bits 7:0) on `nand_dout`.
- R3: A trigger write (register 2) is ignored when bits 5:0 are zero or have more than one bit set, or when an operation is already running. An ignored write produces no strobe and leaves the completion flag unchanged.
- R4: Bit 15 of register 2 reads 1 once an operation completes. It stays 1 until the next trigger is accepted, and it reads 0 from the cycle after acceptance.
- R5: Trigger 0x0004 (program) makes PAGE_BYTES write strobes with CLE and ALE low. Each strobe carries `buf_rdata` for the current `buf_byte`, counting from 0. After the last strobe the block waits TWB_CYC cycles and then for `nand_rb` = 1 before it sets completion.
- R6: Trigger 0x0008 (page read) first waits for `nand_rb` = 1 and issues no read strobe while the line is low. It then makes PAGE_BYTES read strobes. Each byte on `nand_din` is passed to the buffer with a `buf_we` pulse at index 0, 1, 2 and so on.
- R7: Trigger 0x0010 (ID read) makes ID_BYTES read strobes and trigger 0x0020 (status read) makes one read strobe. Each captured byte goes to the buffer, and neither operation waits on `nand_rb`.
- R8: Accepting a program, read, ID or status trigger clears the buffer pointer (register 3, bits 2:0) to 0. Command and address triggers leave it unchanged, and the chip-select field (register 3, bits 6:5) is never altered by a trigger.
- R9: `nand_ce_n[k]` is low only when the chip-enable bit (register 4, bit 7) is 1 and the chip-select field equals k. All enables are high when bit 7 is 0.
- R10: Writing 1 to register 4 bit 6 aborts any running operation and clears the completion flag. Bit 6 then reads 1 for RST_CYCLES cycles and returns to 0 by itself.
- R11: Register 4 bits 10:9 hold a pages-per-block code, and `blk_pages` shows 32, 64, 128 or 256 for the codes 0 to 3.
- R12: CLE and ALE are never high together, and the write and read strobes are never low together. After reset all strobes are high, CLE and ALE are low and all chip enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 cmd, 1 addr, 2 trigger/flag, 3 buffer control, 4 config) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register at `reg_addr` |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 4 | Chip enables, active low |
| nand_dout | output | 8 | Byte driven toward the device |
| nand_din | input | 8 | Byte returned by the device |
| nand_rb | input | 1 | Device ready (1) / busy (0) |
| buf_sel | output | 3 | Buffer area pointer |
| buf_byte | output | BW | Byte index within the transfer |
| buf_rdata | input | 8 | Buffer byte for program transfers |
| buf_we | output | 1 | Buffer write pulse for captured bytes |
| buf_wdata | output | 8 | Captured byte |
| blk_pages | output | 9 | Decoded pages per block |

## Verification
A wrong operation register or byte counter shows up at the pins within one strobe period. Either the strobe count is wrong or the wrong byte appears on `nand_dout` or `buf_wdata`, which is why the bench counts every strobe by latch type and compares every transferred byte. A stuck or misordered sequencer state shows up in one of two ways: a completion flag that rises while `nand_rb` is held low, or a flag that never rises within the poll limit. Both are observable in the cycles right after the test holds the ready line low. A pointer or chip-select field that is wrongly kept or cleared is seen immediately through register readback and the chip-enable pins.

// File: rtl/nand_op_seq.sv
module nand_op_seq #(
  parameter int PAGE_BYTES = 16,
  parameter int ID_BYTES   = 4,
  parameter int PULSE_W    = 2,
  parameter int TWB_CYC    = 3,
  parameter int RST_CYCLES = 8,
  localparam int BW = $clog2(PAGE_BYTES + 1),
  localparam int CW = $clog2(RST_CYCLES + PULSE_W + TWB_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic [3:0]    nand_ce_n,
  output logic [7:0]    nand_dout,
  input  logic [7:0]    nand_din,
  input  logic          nand_rb,
  output logic [2:0]    buf_sel,
  output logic [BW-1:0] buf_byte,
  input  logic [7:0]    buf_rdata,
  output logic          buf_we,
  output logic [7:0]    buf_wdata,
  output logic [8:0]    blk_pages
);

  typedef enum logic [2:0] {S_IDLE, S_LOW, S_HIGH, S_TWB, S_WRB, S_RST} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  idx;
  logic [5:0]     op_q;
  logic [7:0]     cmd_q, addr_q;
  logic [2:0]     ptr_q;
  logic [1:0]     cs_q, ppb_q;
  logic           ce_q, done_q;

  wire [5:0] trig     = reg_wdata[5:0];
  wire       trig_we  = reg_we && reg_addr == 3'd2;
  wire       trig_ok  = trig != 6'd0 && (trig & (trig - 6'd1)) == 6'd0;
  wire       rst_go   = reg_we && reg_addr == 3'd4 && reg_wdata[6] && st != S_RST;
  wire       accept   = trig_we && trig_ok && st == S_IDLE && !rst_go;
  wire       is_rd    = |op_q[5:3];
  wire       low      = st == S_LOW;
  wire       active   = low || st == S_HIGH;
  wire       pulse_end = cnt == CW'(PULSE_W - 1);

  logic [BW-1:0] last_idx;
  always_comb begin
    if (op_q[2] || op_q[3]) last_idx = BW'(PAGE_BYTES - 1);
    else if (op_q[4])       last_idx = BW'(ID_BYTES - 1);
    else                    last_idx = '0;
  end

  assign nand_cle  = active && op_q[0];
  assign nand_ale  = active && op_q[1];
  assign nand_we_n = !(low && !is_rd);
  assign nand_re_n = !(low && is_rd);
  assign nand_dout = op_q[0] ? cmd_q : op_q[1] ? addr_q : op_q[2] ? buf_rdata : 8'h00;
  assign buf_we    = low && is_rd && pulse_end;
  assign buf_wdata = nand_din;
  assign buf_byte  = idx;
  assign buf_sel   = ptr_q;
  assign blk_pages = 9'd32 << ppb_q;

  for (genvar k = 0; k < 4; k++) begin : g_ce
    assign nand_ce_n[k] = !(ce_q && cs_q == 2'(k));
  end

  wire [5:0] op_vis = (st != S_IDLE && st != S_RST) ? op_q : 6'd0;
  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {8'h00, cmd_q};
      3'd1:    reg_rdata = {8'h00, addr_q};
      3'd2:    reg_rdata = {done_q, 9'd0, op_vis};
      3'd3:    reg_rdata = {9'd0, cs_q, 2'b00, ptr_q};
      3'd4:    reg_rdata = {5'd0, ppb_q, 1'b0, ce_q, st == S_RST, 6'd0};
      default: reg_rdata = 16'h0000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; addr_q <= '0; ptr_q <= '0; cs_q <= '0; ce_q <= 1'b0; ppb_q <= '0;
    end else begin
      if (reg_we && reg_addr == 3'd0) cmd_q <= reg_wdata[7:0];
      if (reg_we && reg_addr == 3'd1) addr_q <= reg_wdata[7:0];
      if (reg_we && reg_addr == 3'd3) begin
        ptr_q <= reg_wdata[2:0];
        cs_q  <= reg_wdata[6:5];
      end
      if (reg_we && reg_addr == 3'd4) begin
        ce_q  <= reg_wdata[7];
        ppb_q <= reg_wdata[10:9];
      end
      if (accept && |trig[5:2]) ptr_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; op_q <= '0; done_q <= 1'b0;
    end else if (rst_go) begin
      st <= S_RST; cnt <= '0; op_q <= '0; done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_q <= trig; done_q <= 1'b0; idx <= '0; cnt <= '0;
          st <= trig[3] ? S_TWB : S_LOW;
        end
        S_LOW: if (pulse_end) begin cnt <= '0; st <= S_HIGH; end
               else cnt <= cnt + 1'b1;
        S_HIGH: if (pulse_end) begin
          cnt <= '0;
          if (idx == last_idx) begin
            if (op_q[2]) st <= S_TWB;
            else begin st <= S_IDLE; done_q <= 1'b1; end
          end else begin
            idx <= idx + 1'b1; st <= S_LOW;
          end
        end else cnt <= cnt + 1'b1;
        S_TWB: if (cnt == CW'(TWB_CYC - 1)) begin cnt <= '0; st <= S_WRB; end
               else cnt <= cnt + 1'b1;
        S_WRB: if (nand_rb) begin
          if (op_q[2]) begin st <= S_IDLE; done_q <= 1'b1; end
          else st <= S_LOW;
        end
        S_RST: if (cnt == CW'(RST_CYCLES - 1)) begin cnt <= '0; st <= S_IDLE; end
               else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PINS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale) && (nand_we_n || nand_re_n)); // R12
  AST_BAD_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_we && !trig_ok && st == S_IDLE && !rst_go) |=> (st == S_IDLE && $stable(done_q))); // R3
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_q); // R4
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && |trig[5:2]) |=> ptr_q == 3'd0); // R8
  AST_PROG_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRB && op_q[2] && !nand_rb && !rst_go) |=> !done_q); // R5
  AST_READ_WAITS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WRB && op_q[3] && !nand_rb) |=> nand_re_n); // R6
  AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~nand_ce_n) <= 1); // R9
  AST_RST_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_go |=> (st == S_RST && !done_q && nand_we_n && nand_re_n)); // R10

endmodule

// File: tb/test_nand_op_seq.sv
module test_nand_op_seq;
  localparam int PAGE = 16;
  localparam int IDB  = 4;
  localparam int BW   = $clog2(PAGE + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_rb = 1'b1, buf_we;
  logic [3:0] nand_ce_n;
  logic [7:0] nand_dout, nand_din, buf_rdata, buf_wdata;
  logic [2:0] buf_sel;
  logic [BW-1:0] buf_byte;
  logic [8:0] blk_pages;

  int checks = 0, errors = 0;
  int n_cle = 0, n_ale = 0, n_wd = 0, n_re = 0, n_bw = 0, re_rise = 0, derr = 0;
  int last_bb = -1;
  logic [7:0] last_cmd = '0, last_adr = '0;
  logic we_q = 1'b1, re_q = 1'b1;

  always #5ns clk = ~clk;

  nand_op_seq #(.PAGE_BYTES(PAGE), .ID_BYTES(IDB)) i_nand_op_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_ce_n(nand_ce_n), .nand_dout(nand_dout), .nand_din(nand_din),
    .nand_rb(nand_rb), .buf_sel(buf_sel), .buf_byte(buf_byte), .buf_rdata(buf_rdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .blk_pages(blk_pages));

  assign buf_rdata = 8'hC0 ^ 8'(buf_byte);
  assign nand_din  = 8'(re_rise * 3 + 1);

  always @(negedge clk) begin
    if (we_q && !nand_we_n) begin
      if (nand_cle) begin n_cle++; last_cmd = nand_dout; end
      else if (nand_ale) begin n_ale++; last_adr = nand_dout; end
      else begin
        n_wd++;
        if (nand_dout != (8'hC0 ^ 8'(buf_byte))) derr++;
      end
    end
    if (re_q && !nand_re_n) n_re++;
    if (!re_q && nand_re_n) re_rise++;
    if (buf_we) begin
      n_bw++;
      if (buf_wdata != 8'(re_rise * 3 + 1) || buf_sel != 3'd0) derr++;
      if (!(int'(buf_byte) == 0 || int'(buf_byte) == last_bb + 1)) derr++;
      last_bb = int'(buf_byte);
    end
    we_q = nand_we_n;
    re_q = nand_re_n;
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1ns;
    d = reg_rdata;
  endtask

  task automatic poll(output bit ok);
    logic [15:0] v;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd2, v);
      if (v[15]) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  function automatic string tag_of(input logic [7:0] t);
    case (t)
      8'h01: return "R1";
      8'h02: return "R2";
      8'h04: return "R5";
      8'h08: return "R6";
      8'h10, 8'h20: return "R7";
      default: return "R3";
    endcase
  endfunction

  // cmd, addr, trigger, accepted, cle strobes, ale strobes, data writes, reads
  localparam logic [63:0] VEC [0:13] = '{
    {8'h90, 8'h00, 8'h01, 8'd1, 8'd1, 8'd0, 8'd0,  8'd0},
    {8'h90, 8'h00, 8'h02, 8'd1, 8'd0, 8'd1, 8'd0,  8'd0},
    {8'h90, 8'h00, 8'h10, 8'd1, 8'd0, 8'd0, 8'd0,  8'd4},
    {8'h90, 8'h00, 8'h00, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0},
    {8'h70, 8'h00, 8'h01, 8'd1, 8'd1, 8'd0, 8'd0,  8'd0},
    {8'h70, 8'h00, 8'h20, 8'd1, 8'd0, 8'd0, 8'd0,  8'd1},
    {8'h70, 8'h00, 8'h03, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0},
    {8'h80, 8'h00, 8'h01, 8'd1, 8'd1, 8'd0, 8'd0,  8'd0},
    {8'h80, 8'h12, 8'h02, 8'd1, 8'd0, 8'd1, 8'd0,  8'd0},
    {8'h80, 8'h12, 8'h04, 8'd1, 8'd0, 8'd0, 8'd16, 8'd0},
    {8'h00, 8'h12, 8'h01, 8'd1, 8'd1, 8'd0, 8'd0,  8'd0},
    {8'h00, 8'h12, 8'h08, 8'd1, 8'd0, 8'd0, 8'd0,  8'd16},
    {8'h00, 8'h12, 8'h40, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0},
    {8'h00, 8'h12, 8'h30, 8'd0, 8'd0, 8'd0, 8'd0,  8'd0}
  };

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    bit ok;
    int b_cle, b_ale, b_wd, b_re, b_bw, b_derr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd2, v); chk(int'(v), 0, "R4 reset flag");
    chk(int'(nand_ce_n), 4'hF, "R9 reset enables");
    chk(int'({nand_we_n, nand_re_n, nand_cle, nand_ale}), 4'b1100, "R12 reset pins");
    chk(int'(blk_pages), 32, "R11 reset pages");

    for (int r = 0; r < 14; r++) begin
      logic [7:0] f_cmd, f_adr, f_trg, f_acc, f_cle, f_ale, f_wd, f_re;
      {f_cmd, f_adr, f_trg, f_acc, f_cle, f_ale, f_wd, f_re} = VEC[r];
      wr(3'd0, {8'h00, f_cmd});
      wr(3'd1, {8'h00, f_adr});
      b_cle = n_cle; b_ale = n_ale; b_wd = n_wd; b_re = n_re; b_bw = n_bw; b_derr = derr;
      wr(3'd2, {8'h00, f_trg});
      if (f_acc != 0) begin
        poll(ok);
        chk(int'(ok), 1, {tag_of(f_trg), " completion R4"});
      end else begin
        repeat (20) @(negedge clk);
        rd(3'd2, v);
        chk(int'(v[15]), 1, "R3 flag kept on ignored trigger");
      end
      chk(n_cle - b_cle, int'(f_cle), {tag_of(f_trg), " cle strobes"});
      chk(n_ale - b_ale, int'(f_ale), {tag_of(f_trg), " ale strobes"});
      chk(n_wd - b_wd, int'(f_wd), {tag_of(f_trg), " data writes"});
      chk(n_re - b_re, int'(f_re), {tag_of(f_trg), " read strobes"});
      chk(n_bw - b_bw, int'(f_re), {tag_of(f_trg), " buffer writes"});
      chk(derr - b_derr, 0, {tag_of(f_trg), " byte values"});
      if (f_cle != 0) chk(int'(last_cmd), int'(f_cmd), "R1 command byte");
      if (f_ale != 0) chk(int'(last_adr), int'(f_adr), "R2 address byte");
      if (f_trg == 8'h08) chk(last_bb, PAGE - 1, "R6 last buffer index");
    end

    // R4 flag clears on accept; R3 busy trigger ignored
    b_cle = n_cle; b_re = n_re;
    wr(3'd2, 16'h0010);
    rd(3'd2, v); chk(int'(v[15]), 0, "R4 flag cleared on accept");
    wr(3'd2, 16'h0001);
    poll(ok); chk(int'(ok), 1, "R7 id completion");
    chk(n_cle - b_cle, 0, "R3 busy trigger ignored");
    chk(n_re - b_re, IDB, "R7 id strobes");

    // R8 pointer handling
    wr(3'd3, 16'h0025);
    wr(3'd2, 16'h0001); poll(ok);
    rd(3'd3, v); chk(int'(v), 16'h0025, "R8 pointer kept by command");
    wr(3'd2, 16'h0020); poll(ok);
    rd(3'd3, v); chk(int'(v), 16'h0020, "R8 pointer cleared by status");

    // R9 chip enables
    wr(3'd3, 16'h0040);
    wr(3'd4, 16'h0080);
    chk(int'(nand_ce_n), 4'b1011, "R9 enable cs2");
    wr(3'd4, 16'h0000);
    chk(int'(nand_ce_n), 4'b1111, "R9 enable off");

    // R11 pages per block
    for (int c = 0; c < 4; c++) begin
      wr(3'd4, 16'(c << 9));
      chk(int'(blk_pages), 32 << c, "R11 decoded pages");
      rd(3'd4, v); chk(int'(v[10:9]), c, "R11 code readback");
    end

    // R5 program waits for ready
    nand_rb = 1'b0; b_wd = n_wd;
    wr(3'd2, 16'h0004);
    repeat (120) @(negedge clk);
    chk(n_wd - b_wd, PAGE, "R5 program strobes");
    rd(3'd2, v); chk(int'(v[15]), 0, "R5 flag held while busy");
    nand_rb = 1'b1;
    poll(ok); chk(int'(ok), 1, "R5 completion after ready");

    // R6 read waits for ready
    nand_rb = 1'b0; b_re = n_re;
    wr(3'd2, 16'h0008);
    repeat (40) @(negedge clk);
    chk(n_re - b_re, 0, "R6 no read strobe while busy");
    rd(3'd2, v); chk(int'(v[15]), 0, "R6 flag held while busy");
    nand_rb = 1'b1;
    poll(ok); chk(int'(ok), 1, "R6 completion");
    chk(n_re - b_re, PAGE, "R6 read strobes");

    // R10 soft reset
    wr(3'd4, 16'h0040);
    rd(3'd4, v); chk(int'(v[6]), 1, "R10 reset bit busy");
    rd(3'd2, v); chk(int'(v[15]), 0, "R10 flag cleared");
    repeat (12) @(negedge clk);
    rd(3'd4, v); chk(int'(v[6]), 0, "R10 reset bit self clears");
    nand_rb = 1'b0;
    wr(3'd2, 16'h0004);
    repeat (120) @(negedge clk);
    wr(3'd4, 16'h0040);
    nand_rb = 1'b1;
    repeat (30) @(negedge clk);
    rd(3'd2, v); chk(int'(v), 0, "R10 aborted program never completes");
    chk(int'({nand_we_n, nand_re_n, nand_cle, nand_ale}), 4'b1100, "R12 pins idle after abort");
    chk(derr, 0, "R5 total byte errors");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule